// File: doc/BRIEF.md
# Loaded Battery Test Sequencer

This block decides when a backup cell is put under load and judged. Once supply power has been good for a recovery delay, it turns on a test load for a fixed window. During that window it watches a comparator that reports the cell sagging below its threshold. A single low reading anywhere in the window marks the cell as weak and drives an active-low warning. The load itself and the comparator sit outside the block; it sees only their digital faces.

While no warning is active, tests are spaced by a long interval. Once a warning is active, it is latched, and tests are spaced by a short interval so that a cell swap is noticed quickly. A detach only counts as a swap when the cell-present input stays low for at least a minimum number of ticks. After a real swap, the next passing test clears the warning. The first test after every power-up is a full reassessment, and a pass there clears the warning even with no swap. Losing power stops everything at once: the load drops, the open test verdict is thrown away, and the warning keeps its value.

All durations are counted in pulses of a timing tick input. Each duration is a parameter, so the real day-long spacing and scaled-down values use the same logic.

Top module: `bat_test_seq`

## Requirements
- R1: While reset is asserted and right after it is released, load_en_o is 0 and warn_n_o is 1 (1 = no warning, 0 = warning).
- R2: After pwr_ok_i rises, load_en_o rises once RECOV_TICKS tick pulses have been counted. The tick sampled in the same cycle as the power rise does not count.
- R3: Each test holds load_en_o high for exactly PULSE_TICKS tick pulses.
- R4: If bat_low_i is 1 in any cycle of a test window, warn_n_o goes to 0 in the same cycle that load_en_o falls.
- R5: While warn_n_o is 1, the next test starts NORMAL_TICKS tick pulses after the previous window ends.
- R6: While warn_n_o is 0, the next test starts WARN_TICKS tick pulses after the previous window ends.
- R7: A passing test does not clear an active warning unless a qualifying swap was seen. A detach of fewer than DETACH_TICKS tick pulses does not qualify.
- R8: Suppose bat_present_i stays 0 for at least DETACH_TICKS tick pulses and then returns to 1. The next passing test then sets warn_n_o to 1, and spacing returns to NORMAL_TICKS.
- R9: When pwr_ok_i falls, load_en_o is 0 in that same cycle. No test runs while power is down. A window cut short by power loss leaves warn_n_o unchanged.
- R10: The first test after each power-up clears an active warning when it passes, even if no swap was seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle timing pulse that advances every interval |
| pwr_ok_i | input | 1 | Supply within tolerance |
| bat_low_i | input | 1 | Comparator: loaded cell below threshold |
| bat_present_i | input | 1 | A cell is attached |
| load_en_o | output | 1 | Connect the test load to the cell |
| warn_n_o | output | 1 | Battery warning, active low (drives an open-drain pad) |

## Verification
Most internal faults show up in how output edges are spaced in tick pulses. A timer that compares against the wrong limit stretches or shortens the window, the recovery delay or one of the two cadences on the very next edge. A verdict, power-up or swap flag in the wrong state appears at the end of the following test window, when warn_n_o either moves when it should not or fails to move. The bench records every change of the two outputs together with the number of ticks since the previous event. A bad flag is therefore caught within one test period of the stimulus that should have set it.

// File: rtl/bts_pkg.sv
package bts_pkg;

   typedef enum logic [1:0] {
      SEQ_OFF  = 2'd0,
      SEQ_WAIT = 2'd1,
      SEQ_TEST = 2'd2,
      SEQ_GAP  = 2'd3
   } seq_state_e;

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/bts_tick_timer.sv
module bts_tick_timer #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         tick_i,
   input  logic [W-1:0] limit_i,
   output logic         hit_o
);

   logic [W-1:0] cnt_q;

   assign hit_o = tick_i && (cnt_q == (limit_i - W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i || hit_o) begin
         cnt_q <= '0;
      end else if (tick_i) begin
         cnt_q <= cnt_q + W'(1);
      end
   end

   // R3: a window or gap never runs past its limit
   p_cnt_below_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < limit_i);

endmodule

// File: rtl/bts_detach_mon.sv
module bts_detach_mon #(
   parameter int unsigned DETACH_TICKS = 7000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic bat_present_i,
   output logic swap_o
);

   logic seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= 1'b1;
      else        seen_q <= bat_present_i;
   end

   generate
      if (DETACH_TICKS == 0) begin : g_any_detach
         assign swap_o = bat_present_i && !seen_q;
      end else begin : g_timed_detach
         localparam int unsigned DW = $clog2(DETACH_TICKS + 1);
         localparam logic [DW-1:0] SAT = DW'(DETACH_TICKS);
         logic [DW-1:0] away_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               away_q <= '0;
            end else if (bat_present_i) begin
               away_q <= '0;
            end else if (tick_i && (away_q != SAT)) begin
               away_q <= away_q + DW'(1);
            end
         end

         assign swap_o = bat_present_i && !seen_q && (away_q == SAT);

         // R8: the detach counter saturates at its threshold
         p_detach_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
            away_q <= SAT);
      end
   endgenerate

endmodule

// File: rtl/bat_test_seq.sv
module bat_test_seq
   import bts_pkg::*;
#(
   parameter int unsigned RECOV_TICKS  = 125,
   parameter int unsigned NORMAL_TICKS = 86_400_000,
   parameter int unsigned WARN_TICKS   = 5000,
   parameter int unsigned PULSE_TICKS  = 1000,
   parameter int unsigned DETACH_TICKS = 7000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic pwr_ok_i,
   input  logic bat_low_i,
   input  logic bat_present_i,
   output logic load_en_o,
   output logic warn_n_o
);

   localparam int unsigned MAX_T = umax(umax(RECOV_TICKS, NORMAL_TICKS),
                                        umax(WARN_TICKS, PULSE_TICKS));
   localparam int unsigned CNT_W = $clog2(MAX_T + 1);

   initial begin : p_param_check
      assert (RECOV_TICKS  >= 1) else $error("RECOV_TICKS must be at least 1");
      assert (NORMAL_TICKS >= 1) else $error("NORMAL_TICKS must be at least 1");
      assert (WARN_TICKS   >= 1) else $error("WARN_TICKS must be at least 1");
      assert (PULSE_TICKS  >= 1) else $error("PULSE_TICKS must be at least 1");
   end

   seq_state_e       st_q, st_d;
   logic [CNT_W-1:0] lim;
   logic             hit, tmr_clr, test_done, verdict_low, swap_p;
   logic             fail_q, first_q, swap_q, warn_q;

   always_comb begin
      unique case (st_q)
         SEQ_TEST: lim = CNT_W'(PULSE_TICKS);
         SEQ_GAP:  lim = warn_q ? CNT_W'(WARN_TICKS) : CNT_W'(NORMAL_TICKS);
         default:  lim = CNT_W'(RECOV_TICKS);
      endcase
   end

   always_comb begin
      st_d = st_q;
      if (!pwr_ok_i) begin
         st_d = SEQ_OFF;
      end else begin
         unique case (st_q)
            SEQ_OFF:  st_d = SEQ_WAIT;
            SEQ_WAIT: if (hit) st_d = SEQ_TEST;
            SEQ_TEST: if (hit) st_d = SEQ_GAP;
            SEQ_GAP:  if (hit) st_d = SEQ_TEST;
            default:  st_d = SEQ_OFF;
         endcase
      end
   end

   assign tmr_clr     = (st_d != st_q) || (st_q == SEQ_OFF);
   assign test_done   = (st_q == SEQ_TEST) && hit && pwr_ok_i;
   assign verdict_low = fail_q || bat_low_i;

   bts_tick_timer #(.W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (tmr_clr),
      .tick_i  (tick_i),
      .limit_i (lim),
      .hit_o   (hit)
   );

   bts_detach_mon #(.DETACH_TICKS(DETACH_TICKS)) u_detach (
      .clk           (clk),
      .rst_n         (rst_n),
      .tick_i        (tick_i),
      .bat_present_i (bat_present_i),
      .swap_o        (swap_p)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= SEQ_OFF;
         fail_q  <= 1'b0;
         first_q <= 1'b0;
         swap_q  <= 1'b0;
         warn_q  <= 1'b0;
      end else begin
         st_q <= st_d;

         if (st_q != SEQ_TEST) fail_q <= 1'b0;
         else                  fail_q <= fail_q || bat_low_i;

         if (st_q == SEQ_OFF && pwr_ok_i) first_q <= 1'b1;
         else if (test_done)              first_q <= 1'b0;

         if (test_done)   swap_q <= 1'b0;
         else if (swap_p) swap_q <= 1'b1;

         if (test_done) begin
            if (verdict_low)                       warn_q <= 1'b1;
            else if (first_q || swap_q || swap_p)  warn_q <= 1'b0;
         end
      end
   end

   assign load_en_o = (st_q == SEQ_TEST) && pwr_ok_i;
   assign warn_n_o  = !warn_q;

   // R4: the warning is raised only as a window closes into a gap
   p_warn_set_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(warn_n_o) |-> ($past(st_q) == SEQ_TEST) && (st_q == SEQ_GAP));

   // R7: the warning holds its value except at the close of a window
   p_warn_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(($past(st_q) == SEQ_TEST) && (st_q == SEQ_GAP)) |-> $stable(warn_n_o));

   // R8: a clear needs a swap or a power-up reassessment
   p_clear_qualified_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(warn_n_o) |-> $past(first_q || swap_q || swap_p));

   // R9: one cycle without power always leaves the sequencer parked
   p_parked_unpowered_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!pwr_ok_i) |-> (st_q == SEQ_OFF));

   // R5: a window is entered only from the recovery wait or a gap
   p_test_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SEQ_TEST) && ($past(st_q) != SEQ_TEST)
         |-> ($past(st_q) == SEQ_WAIT) || ($past(st_q) == SEQ_GAP));

endmodule

// File: tb/tb_bat_test_seq.sv
`timescale 1ns/1ps
module tb_bat_test_seq;

   localparam int unsigned T_RECOV  = 5;
   localparam int unsigned T_NORMAL = 20;
   localparam int unsigned T_WARN   = 6;
   localparam int unsigned T_PULSE  = 3;
   localparam int unsigned T_DETACH = 8;

   logic clk = 1'b0;
   logic rst_n, tick, pwr_ok, bat_low, bat_present;
   logic load_en, warn_n;

   always #2.5 clk = ~clk;

   bat_test_seq #(
      .RECOV_TICKS  (T_RECOV),
      .NORMAL_TICKS (T_NORMAL),
      .WARN_TICKS   (T_WARN),
      .PULSE_TICKS  (T_PULSE),
      .DETACH_TICKS (T_DETACH)
   ) dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .tick_i        (tick),
      .pwr_ok_i      (pwr_ok),
      .bat_low_i     (bat_low),
      .bat_present_i (bat_present),
      .load_en_o     (load_en),
      .warn_n_o      (warn_n)
   );

   typedef struct {
      logic  ld;
      logic  wn;
      int    ticks;
      string req;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0;
   int   n_err = 0;
   bit   done  = 0;

   task automatic expect_ev(input logic ld, input logic wn, input int ticks, input string req);
      exp_t e;
      e.ld = ld; e.wn = wn; e.ticks = ticks; e.req = req;
      q.push_back(e);
   endtask

   task automatic check_now(input string req, input logic act, input logic exp_v, input string what);
      n_chk++;
      if (act !== exp_v) begin
         n_err++;
         $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp_v);
      end
   endtask

   task automatic drain();
      while (q.size() != 0) @(negedge clk);
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   endtask

   // tick generator: one pulse every third cycle
   initial begin
      int ph = 0;
      tick = 1'b0;
      forever begin
         @(posedge clk);
         #1;
         ph = (ph + 1) % 3;
         tick = (ph == 0);
      end
   end

   // monitor: every output change is popped against the scoreboard
   initial begin
      logic p_ld = 1'b0;
      logic p_wn = 1'b1;
      logic p_pw = 1'b0;
      int   cnt  = 0;
      forever begin
         @(negedge clk);
         if (!rst_n) begin
            p_ld = load_en; p_wn = warn_n; p_pw = pwr_ok; cnt = 0;
         end else if (pwr_ok && !p_pw) begin
            cnt = 0;
            p_pw = pwr_ok;
         end else begin
            p_pw = pwr_ok;
            if (load_en !== p_ld || warn_n !== p_wn) begin
               n_chk++;
               if (q.size() == 0) begin
                  n_err++;
                  $display("FAIL unexpected event (R9/R5) actual ld=%0b wn=%0b ticks=%0d expected no event",
                           load_en, warn_n, cnt);
               end else begin
                  exp_t e;
                  e = q.pop_front();
                  if (load_en !== e.ld || warn_n !== e.wn ||
                      (e.ticks >= 0 && cnt != e.ticks)) begin
                     n_err++;
                     $display("FAIL %s actual ld=%0b wn=%0b ticks=%0d expected ld=%0b wn=%0b ticks=%0d",
                              e.req, load_en, warn_n, cnt, e.ld, e.wn, e.ticks);
                  end
               end
               p_ld = load_en; p_wn = warn_n;
               cnt = 0;
            end
            if (tick) cnt++;
         end
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      finish_run();
   end

   // driver
   initial begin
      rst_n = 1'b0; pwr_ok = 1'b0; bat_low = 1'b0; bat_present = 1'b1;
      step(8);
      @(negedge clk);
      check_now("R1", load_en, 1'b0, "load_en in reset");
      check_now("R1", warn_n, 1'b1, "warn_n in reset");
      step(1);
      rst_n = 1'b1;
      step(4);
      @(negedge clk);
      check_now("R1", load_en, 1'b0, "load_en after reset");
      check_now("R1", warn_n, 1'b1, "warn_n after reset");

      // power-up, recovery delay, window and normal cadence
      expect_ev(1, 1, T_RECOV,  "R2");
      expect_ev(0, 1, T_PULSE,  "R3");
      expect_ev(1, 1, T_NORMAL, "R5");
      expect_ev(0, 1, T_PULSE,  "R3");
      step(1);
      pwr_ok = 1'b1;
      drain();

      // weak cell sets the warning
      step(1);
      bat_low = 1'b1;
      expect_ev(1, 1, T_NORMAL, "R5");
      expect_ev(0, 0, T_PULSE,  "R4");
      drain();
      step(1);
      bat_low = 1'b0;

      // fast cadence, passing test does not clear
      expect_ev(1, 0, T_WARN,  "R6");
      expect_ev(0, 0, T_PULSE, "R7");
      drain();

      // short detach does not qualify
      expect_ev(1, 0, T_WARN,  "R6");
      expect_ev(0, 0, T_PULSE, "R7");
      step(1);
      bat_present = 1'b0; bat_low = 1'b1;
      step(9);
      bat_present = 1'b1; bat_low = 1'b0;
      drain();

      // long detach: failing test while away, then a clearing pass
      expect_ev(1, 0, T_WARN,   "R6");
      expect_ev(0, 0, T_PULSE,  "R7");
      expect_ev(1, 0, T_WARN,   "R8");
      expect_ev(0, 1, T_PULSE,  "R8");
      expect_ev(1, 1, T_NORMAL, "R8");
      expect_ev(0, 1, T_PULSE,  "R8");
      step(1);
      bat_present = 1'b0; bat_low = 1'b1;
      step(36);
      bat_present = 1'b1; bat_low = 1'b0;
      drain();

      // warning again, then power loss mid-window
      step(1);
      bat_low = 1'b1;
      expect_ev(1, 1, T_NORMAL, "R5");
      expect_ev(0, 0, T_PULSE,  "R4");
      drain();
      step(1);
      bat_low = 1'b0;
      expect_ev(1, 0, T_WARN, "R6");
      drain();
      expect_ev(0, 0, -1, "R9");
      step(3);
      pwr_ok = 1'b0;
      #1;
      check_now("R9", load_en, 1'b0, "load_en at power loss");
      drain();
      step(90);
      @(negedge clk);
      check_now("R9", warn_n, 1'b0, "warn_n kept while unpowered");
      check_now("R9", load_en, 1'b0, "load_en while unpowered");

      // power-up reassessment clears the warning
      expect_ev(1, 0, T_RECOV,  "R10");
      expect_ev(0, 1, T_PULSE,  "R10");
      expect_ev(1, 1, T_NORMAL, "R10");
      step(1);
      pwr_ok = 1'b1;
      drain();
      step(4);
      finish_run();
   end

endmodule